// File: doc/BRIEF.md
# I2C bus recovery sequencer

This block frees an I2C bus that a slave holds stuck, typically with SDA pinned low after a transfer was cut short. It takes direct open-drain control of both bus lines before the regular bus controller is switched on. A one-cycle start request in the idle state begins a fixed recovery sequence. The block first checks that both lines are released. It then clocks SCL a fixed number of times, nine by default. Before each clock it gives a slave that stretches the clock a bounded amount of time to let SCL go high. It ends by placing a STOP condition on the bus.

Both outputs are open-drain enables: when an enable is high, the line is pulled low. The SCL pad level comes back through a two-flop synchronizer. The time base is set by a ticks-per-microsecond parameter. The low and high halves of each clock, and the limit on the stretch wait, are whole numbers of microseconds. A one-cycle done pulse marks the end of the sequence. A sticky flag reports whether any stretch wait ran out.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, scl_oe, sda_oe, done and stretch_timeout are all 0, and both lines are released.
- R2: A start pulse seen in the idle state produces exactly PULSES (default 9) SCL clock pulses. A clock pulse is a period with scl_oe high while sda_oe is 0. sda_oe stays 0 throughout the clocking.
- R3: Each clock pulse holds scl_oe at 1 for HALF_US*TICKS_PER_US cycles. scl_oe then stays at 0 for the same number of cycles before the next stretch check.
- R4: The synchronized SCL input lags the pad level by two clock cycles. Before each pulse, the block waits while that synchronized level reads 0. The low half of the pulse begins on the edge after the level is seen as 1.
- R5: A stretch wait lasts at most STRETCH_US*TICKS_PER_US cycles. When the limit is reached, the pulse is driven anyway and stretch_timeout is set. The flag holds until the next accepted start, which clears it.
- R6: After the last pulse, the STOP takes three half periods. In the first, scl_oe is driven 1. In the second, sda_oe is also driven 1 while scl_oe stays 1. In the third, scl_oe is released to 0 while sda_oe stays 1. sda_oe is then released.
- R7: done is 1 for exactly one cycle, the same cycle in which sda_oe first reads 0 after the STOP. After that cycle the block is idle again.
- R8: A start pulse that arrives while a sequence is running has no effect. The sequence keeps its pulse count, timing and single done pulse, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin recovery (used only when idle) |
| scl_in | input | 1 | SCL pad level, asynchronous to clk |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| done | output | 1 | One-cycle end-of-sequence pulse |
| stretch_timeout | output | 1 | Some stretch wait of the last sequence reached its limit |

## Verification
The bench builds the block with TICKS_PER_US = 2 and STRETCH_US = 60, keeping the default nine pulses and the 5 us half period. Each half period is then 10 cycles and the stretch limit is 120 cycles. A slave hold of 30 cycles therefore ends before the limit, and a hold of 300 cycles runs past it. Several full sequences, each with the STOP, fit in a few thousand cycles. At these values the expiry edge of every counter can be compared cycle by cycle against the behavioural model.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LOW,
    ST_HIGH,
    ST_STOP_SCL,
    ST_STOP_SDA,
    ST_STOP_REL,
    ST_DONE
  } unstick_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import i2c_unstick_pkg::*;
#(
  parameter int TICKS_PER_US = 100,
  parameter int HALF_US = 5,
  parameter int STRETCH_US = 500,
  parameter int PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scl_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic done,
  output logic stretch_timeout
);
  localparam int HALF_TICKS = HALF_US * TICKS_PER_US;
  localparam int WAIT_TICKS = STRETCH_US * TICKS_PER_US;
  localparam int MAX_TICKS = (HALF_TICKS > WAIT_TICKS) ? HALF_TICKS : WAIT_TICKS;
  localparam int TW = $clog2(MAX_TICKS + 1);
  localparam int PW = $clog2(PULSES + 1);

  unstick_state_e state;
  logic [TW-1:0]  tcnt;
  logic [PW-1:0]  pcnt;
  logic           scl_s;
  logic           half_hit, wait_hit, advance, tmr_clr, last_pulse;

  unstick_sync #(.WIDTH(1), .STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s)
  );

  unstick_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .cnt(tcnt)
  );

  assign half_hit   = (tcnt == TW'(HALF_TICKS - 1));
  assign wait_hit   = (tcnt == TW'(WAIT_TICKS - 1));
  assign last_pulse = (pcnt == PW'(PULSES - 1));

  always_comb begin
    case (state)
      ST_IDLE:  advance = start;
      ST_WAIT:  advance = scl_s || wait_hit;
      ST_DONE:  advance = 1'b1;
      default:  advance = half_hit;
    endcase
    tmr_clr = advance || (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      pcnt            <= '0;
      scl_oe          <= 1'b0;
      sda_oe          <= 1'b0;
      done            <= 1'b0;
      stretch_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state           <= ST_WAIT;
          pcnt            <= '0;
          scl_oe          <= 1'b0;
          sda_oe          <= 1'b0;
          stretch_timeout <= 1'b0;
        end
        ST_WAIT: if (advance) begin
          state  <= ST_LOW;
          scl_oe <= 1'b1;
          if (!scl_s) stretch_timeout <= 1'b1;
        end
        ST_LOW: if (advance) begin
          state  <= ST_HIGH;
          scl_oe <= 1'b0;
        end
        ST_HIGH: if (advance) begin
          if (last_pulse) begin
            state  <= ST_STOP_SCL;
            scl_oe <= 1'b1;
          end else begin
            state <= ST_WAIT;
            pcnt  <= pcnt + 1'b1;
          end
        end
        ST_STOP_SCL: if (advance) begin
          state  <= ST_STOP_SDA;
          sda_oe <= 1'b1;
        end
        ST_STOP_SDA: if (advance) begin
          state  <= ST_STOP_REL;
          scl_oe <= 1'b0;
        end
        ST_STOP_REL: if (advance) begin
          state  <= ST_DONE;
          sda_oe <= 1'b0;
          done   <= 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
  parameter int HALF_TICKS = 500,
  parameter int PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic stretch_timeout
);
  logic [31:0] hi_run;
  logic [31:0] rises;
  logic        scl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run   <= '0;
      rises    <= '0;
      scl_prev <= 1'b0;
    end else begin
      scl_prev <= scl_oe;
      hi_run   <= scl_oe ? hi_run + 1 : '0;
      if (done)                    rises <= '0;
      else if (scl_oe && !scl_prev) rises <= rises + 1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!scl_oe && !sda_oe && !done && !stretch_timeout));

  assert_pulse_total_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (rises == PULSES + 1));

  assert_low_width_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_oe) && !sda_oe) |-> (hi_run == HALF_TICKS));

  assert_stop_sda_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> scl_oe);

  assert_stop_sda_rel_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_oe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_on_release_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(sda_oe));
endmodule

bind i2c_bus_unstick unstick_checker #(.HALF_TICKS(HALF_TICKS), .PULSES(PULSES)) u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done(done), .stretch_timeout(stretch_timeout)
);

// File: tb/i2c_bus_unstick_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_unstick_tb_top;
  localparam int TPU = 2;
  localparam int SUS = 60;
  localparam int HALF = 5 * TPU;
  localparam int LIMIT = SUS * TPU;
  localparam int NP = 9;

  logic clk = 0, rst = 1, start = 0, hold_low = 0;
  logic scl_oe, sda_oe, done, stretch_timeout;
  wire  scl_pad = ~(scl_oe | hold_low);

  always #5 clk = ~clk;

  i2c_bus_unstick #(.TICKS_PER_US(TPU), .HALF_US(5), .STRETCH_US(SUS), .PULSES(NP)) dut_i (
    .clk(clk), .rst(rst), .start(start), .scl_in(scl_pad),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .stretch_timeout(stretch_timeout)
  );

  int checks = 0, errors = 0, cycles = 0;

  // behavioural reference: phase 0 idle,1 wait,2 low,3 high,4..6 stop,7 done
  int ph, cnt, np;
  logic q1, q2, e_scl, e_sda, e_done, e_to;
  always @(posedge clk) begin
    if (rst) begin
      ph <= 0; cnt <= 0; np <= 0; q1 <= 1; q2 <= 1;
      e_scl <= 0; e_sda <= 0; e_done <= 0; e_to <= 0;
    end else begin
      q1 <= scl_pad; q2 <= q1; e_done <= 0; cnt <= cnt + 1;
      if (ph == 0) begin
        cnt <= 0;
        if (start) begin ph <= 1; np <= 0; e_to <= 0; end
      end else if (ph == 1) begin
        if (q2 || cnt == LIMIT - 1) begin
          ph <= 2; cnt <= 0; e_scl <= 1;
          if (!q2) e_to <= 1;
        end
      end else if (ph == 7) begin
        ph <= 0; cnt <= 0;
      end else if (cnt == HALF - 1) begin
        cnt <= 0;
        case (ph)
          2: begin ph <= 3; e_scl <= 0; end
          3: if (np == NP - 1) begin ph <= 4; e_scl <= 1; end
             else begin ph <= 1; np <= np + 1; end
          4: begin ph <= 5; e_sda <= 1; end
          5: begin ph <= 6; e_scl <= 0; end
          default: begin ph <= 7; e_sda <= 0; e_done <= 1; end
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison and event counting
  int falls = 0, dones = 0;
  logic p_scl = 0, p_sda = 0;
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R3", scl_oe, e_scl, "scl_oe vs model");
      chk("R6", sda_oe, e_sda, "sda_oe vs model");
      chk("R7", done, e_done, "done vs model");
      chk("R5", stretch_timeout, e_to, "stretch_timeout vs model");
      if (p_scl && !scl_oe && !sda_oe) falls++;
      if (!p_sda && sda_oe) chk("R6", scl_oe, 1'b1, "scl held low at SDA pull");
      if (p_sda && !sda_oe) begin
        chk("R6", scl_oe, 1'b0, "scl released before SDA");
        chk("R7", done, 1'b1, "done with SDA release");
      end
      if (done) dones++;
    end
    p_scl = scl_oe; p_sda = sda_oe;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_start();
    start = 1; tick(1); start = 0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (dones == 0 && guard < 20000) begin tick(1); guard++; end
  endtask

  task automatic stretch_at(input int nfall, input int len);
    int guard = 0;
    while (falls < nfall && guard < 20000) begin tick(1); guard++; end
    tick(3); hold_low = 1; tick(len); hold_low = 0;
  endtask

  task automatic end_run(input logic exp_to, input string tag);
    tick(3);
    chk("R2", (falls == NP), 1'b1, {tag, " nine clock pulses"});
    chk("R7", (dones == 1), 1'b1, {tag, " single done"});
    chk("R5", stretch_timeout, exp_to, {tag, " timeout flag"});
  endtask

  initial begin
    tick(4); rst = 0; tick(1);
    chk("R1", scl_oe, 1'b0, "reset scl_oe");
    chk("R1", sda_oe, 1'b0, "reset sda_oe");
    chk("R1", done, 1'b0, "reset done");
    chk("R1", stretch_timeout, 1'b0, "reset timeout");

    // plain run
    falls = 0; dones = 0; pulse_start(); wait_done(); end_run(1'b0, "plain");

    // short stretch before pulse 4 (R4)
    falls = 0; dones = 0; pulse_start();
    stretch_at(3, 30); wait_done(); end_run(1'b0, "R4 short stretch");

    // long stretch past the limit before pulse 6 (R5)
    falls = 0; dones = 0; pulse_start();
    stretch_at(5, 300); wait_done(); end_run(1'b1, "R5 long stretch");

    // start during a run is ignored (R8); new start clears flag (R5)
    falls = 0; dones = 0; pulse_start();
    chk("R5", stretch_timeout, 1'b0, "flag cleared by new start");
    tick(25); pulse_start(); tick(60); pulse_start();
    wait_done(); end_run(1'b0, "R8 ignored start");
    tick(80);
    chk("R8", (falls == NP && dones == 1), 1'b1, "no second sequence");
    chk("R8", scl_oe, 1'b0, "idle after run");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule